// File: doc/BRIEF.md
# Multi-Channel DMA Control Register and Interrupt Block

This block is the software-visible control plane of a sixteen-channel DMA engine. A simple word-addressed bus gives 32-bit register writes and combinational reads. For each channel the block holds a base address, a line length, a line count, a control word and a line stride. It drives all of them out to the per-channel address sequencers, which sit outside this block.

Software programs a channel's length, count, control and stride first. Writing that channel's base address comes last, and that write sends a one-cycle start pulse to the sequencer. A separate write-only register sends one-cycle stop pulses to every channel whose bit is written as one. Sequencers report completion through per-channel event inputs. Each event sets a sticky status bit. Software clears a status bit by writing a one to it. A per-channel enable mask selects which status bits raise the single combined interrupt line. A loop register turns on ring (wrap-around) operation for a channel only when both of that channel's two bits are set.

Top module: `dmac_regblk`

## Requirements
- R1: After reset every register, every configuration output, `ch_start`, `ch_stop`, `ch_ring` and `irq` are zero.
- R2: Channel n owns four words at byte offset n*0x10. Offset +0x0 holds the base address (32 bits), +0x4 the line length and +0x8 the line count (16 bits each, upper bits read zero), and +0xC the control word. Only control bits [5:0] are kept: [3:0] channel number, bit 4 burst of four words, bit 5 direction memory-to-device. Each value reads back and appears on the matching `cfg_*` slice.
- R3: The stride of channel n sits at 0x100 + n*4. It keeps 16 bits, reads back, and drives `cfg_stride`.
- R4: A write to channel n's base-address word raises `ch_start[n]` alone, for exactly the one cycle after the write edge. Writes to any other word raise no start.
- R5: Writing a mask to 0x140 raises `ch_stop` equal to that mask for the one cycle after the write edge. Reading 0x140 returns zero.
- R6: `ch_evt[n]` sets status bit n at 0x144. The bit stays set until a write to 0x144 has a one in bit n. Zero bits in that write leave status unchanged.
- R7: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: 0x148 holds one interrupt enable bit per channel. `irq` is high exactly when some status bit and its enable bit are both set. It follows any change in status or enable one edge later.
- R9: 0x150 is a 32-bit loop register that reads back in full. `ch_ring[n]` is high only when both bit n and bit n+16 are set.
- R10: Reads of unmapped or non-word-aligned offsets (for example 0x14C, 0x154, 0x1FC, 0x001) return zero. Writes to them change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 9 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_evt | input | NCH | Per-channel completion events from the sequencers |
| ch_start | output | NCH | One-cycle launch pulses |
| ch_stop | output | NCH | One-cycle stop pulses |
| ch_ring | output | NCH | Ring mode enable per channel |
| cfg_addr | output | NCH*32 | Base address per channel, channel n at bits n*32 |
| cfg_xlen | output | NCH*LEN_W | Line length per channel |
| cfg_ylen | output | NCH*LEN_W | Line count per channel |
| cfg_ctrl | output | NCH*6 | Control word per channel |
| cfg_stride | output | NCH*STRIDE_W | Line stride per channel |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect at the rising edge that samples `bus_wr`. Readback is combinational from `bus_addr`, so a value written at one edge can be read in the low phase that follows. Start and stop pulses, status bits and `irq` all come from flops that load at that same edge, so each is due in the cycle right after the write or event. Pulses must be gone again one cycle later. The bench changes inputs only on falling edges and samples in the same low phase, after the edge that produced each result. It checks a pulse once in its due cycle and once in the next cycle.

// File: rtl/dmac_regblk_pkg.sv
package dmac_regblk_pkg;

  localparam int unsigned BUS_AW = 9;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTRL_W = 6;
  localparam int unsigned RING_HI_SHIFT = 16;

  localparam logic [BUS_AW-1:0] OFS_STOP = 9'h140;
  localparam logic [BUS_AW-1:0] OFS_STAT = 9'h144;
  localparam logic [BUS_AW-1:0] OFS_IEN  = 9'h148;
  localparam logic [BUS_AW-1:0] OFS_LOOP = 9'h150;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CH_ADDR,
    SEL_CH_XLEN,
    SEL_CH_YLEN,
    SEL_CH_CTRL,
    SEL_STRIDE,
    SEL_STOP,
    SEL_STAT,
    SEL_IEN,
    SEL_LOOP
  } reg_sel_e;

endpackage

// File: rtl/dmac_rst_sync.sv
module dmac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
  import dmac_regblk_pkg::*;
#(
  parameter int unsigned NCH      = 16,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned STRIDE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  reg_sel_e                 sel,
  input  logic [3:0]               idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [NCH*DATA_W-1:0]    cfg_addr,
  output logic [NCH*LEN_W-1:0]     cfg_xlen,
  output logic [NCH*LEN_W-1:0]     cfg_ylen,
  output logic [NCH*CTRL_W-1:0]    cfg_ctrl,
  output logic [NCH*STRIDE_W-1:0]  cfg_stride,
  output logic [DATA_W-1:0]        rd_data
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic                we_addr, we_xlen, we_ylen, we_ctrl, we_stride;
    logic [DATA_W-1:0]   addr_q;
    logic [LEN_W-1:0]    xlen_q;
    logic [LEN_W-1:0]    ylen_q;
    logic [CTRL_W-1:0]   ctrl_q;
    logic [STRIDE_W-1:0] stride_q;

    // Clock enables, one per register of this channel
    always_comb begin
      we_addr   = wr_en && (sel == SEL_CH_ADDR) && (idx == 4'(ch));
      we_xlen   = wr_en && (sel == SEL_CH_XLEN) && (idx == 4'(ch));
      we_ylen   = wr_en && (sel == SEL_CH_YLEN) && (idx == 4'(ch));
      we_ctrl   = wr_en && (sel == SEL_CH_CTRL) && (idx == 4'(ch));
      we_stride = wr_en && (sel == SEL_STRIDE)  && (idx == 4'(ch));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q   <= '0;
        xlen_q   <= '0;
        ylen_q   <= '0;
        ctrl_q   <= '0;
        stride_q <= '0;
      end else begin
        if (we_addr)   addr_q   <= wdata;
        if (we_xlen)   xlen_q   <= wdata[LEN_W-1:0];
        if (we_ylen)   ylen_q   <= wdata[LEN_W-1:0];
        if (we_ctrl)   ctrl_q   <= wdata[CTRL_W-1:0];
        if (we_stride) stride_q <= wdata[STRIDE_W-1:0];
      end
    end

    assign cfg_addr[ch*DATA_W +: DATA_W]       = addr_q;
    assign cfg_xlen[ch*LEN_W +: LEN_W]         = xlen_q;
    assign cfg_ylen[ch*LEN_W +: LEN_W]         = ylen_q;
    assign cfg_ctrl[ch*CTRL_W +: CTRL_W]       = ctrl_q;
    assign cfg_stride[ch*STRIDE_W +: STRIDE_W] = stride_q;
  end

  // Readback of the selected channel word; sel is only set for idx < NCH
  always_comb begin
    rd_data = '0;
    case (sel)
      SEL_CH_ADDR: rd_data = cfg_addr[int'(idx)*DATA_W +: DATA_W];
      SEL_CH_XLEN: rd_data = DATA_W'(cfg_xlen[int'(idx)*LEN_W +: LEN_W]);
      SEL_CH_YLEN: rd_data = DATA_W'(cfg_ylen[int'(idx)*LEN_W +: LEN_W]);
      SEL_CH_CTRL: rd_data = DATA_W'(cfg_ctrl[int'(idx)*CTRL_W +: CTRL_W]);
      SEL_STRIDE:  rd_data = DATA_W'(cfg_stride[int'(idx)*STRIDE_W +: STRIDE_W]);
      default:     rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dmac_launch.sv
module dmac_launch
  import dmac_regblk_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [3:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCH-1:0]    ch_start,
  output logic [NCH-1:0]    ch_stop,
  output logic [NCH-1:0]    ch_ring,
  output logic [DATA_W-1:0] loop_q
);

  logic [NCH-1:0] start_d;
  logic [NCH-1:0] stop_d;
  logic           loop_we;

  always_comb begin
    start_d = '0;
    if (wr_en && (sel == SEL_CH_ADDR)) begin
      start_d = NCH'(1) << idx;
    end
    stop_d  = (wr_en && (sel == SEL_STOP)) ? wdata[NCH-1:0] : '0;
    loop_we = wr_en && (sel == SEL_LOOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_start <= '0;
      ch_stop  <= '0;
      loop_q   <= '0;
    end else begin
      ch_start <= start_d;
      ch_stop  <= stop_d;
      if (loop_we) loop_q <= wdata;
    end
  end

  // Ring mode needs the low and the high enable bit of a channel
  for (genvar n = 0; n < NCH; n++) begin : g_ring
    assign ch_ring[n] = loop_q[n] & loop_q[n + RING_HI_SHIFT];
  end

endmodule

// File: rtl/dmac_evt_irq.sv
module dmac_evt_irq #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_evt,
  input  logic           clr_we,
  input  logic           ien_we,
  input  logic [NCH-1:0] wmask,
  output logic [NCH-1:0] stat_q,
  output logic [NCH-1:0] ien_q,
  output logic           irq
);

  logic [NCH-1:0] stat_d;
  logic [NCH-1:0] clr_mask;

  // Clear first, then merge events so a same-cycle event survives
  always_comb begin
    clr_mask = clr_we ? wmask : '0;
    stat_d   = (stat_q & ~clr_mask) | ch_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (ien_we) ien_q <= wmask;
    end
  end

  assign irq = |(stat_q & ien_q);

endmodule

// File: rtl/dmac_regblk.sv
module dmac_regblk
  import dmac_regblk_pkg::*;
#(
  parameter int unsigned NCH      = 16,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned STRIDE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BUS_AW-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NCH-1:0]           ch_evt,
  output logic [NCH-1:0]           ch_start,
  output logic [NCH-1:0]           ch_stop,
  output logic [NCH-1:0]           ch_ring,
  output logic [NCH*DATA_W-1:0]    cfg_addr,
  output logic [NCH*LEN_W-1:0]     cfg_xlen,
  output logic [NCH*LEN_W-1:0]     cfg_ylen,
  output logic [NCH*CTRL_W-1:0]    cfg_ctrl,
  output logic [NCH*STRIDE_W-1:0]  cfg_stride,
  output logic                     irq
);

  // NCH may not exceed 16: the ring mask pairs bit n with bit n+16
  logic              rst_sync_n;
  reg_sel_e          hit_sel;
  logic [3:0]        hit_idx;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] loop_q;
  logic [NCH-1:0]    stat_q;
  logic [NCH-1:0]    ien_q;
  logic              clr_we;
  logic              ien_we;

  dmac_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Address decode: channel words, strides, then the shared registers
  always_comb begin
    hit_sel = SEL_NONE;
    hit_idx = bus_addr[7:4];
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr[8] == 1'b0) begin
        if (int'(bus_addr[7:4]) < NCH) begin
          case (bus_addr[3:2])
            2'd0:    hit_sel = SEL_CH_ADDR;
            2'd1:    hit_sel = SEL_CH_XLEN;
            2'd2:    hit_sel = SEL_CH_YLEN;
            default: hit_sel = SEL_CH_CTRL;
          endcase
        end
      end else if (bus_addr[7:6] == 2'b00) begin
        hit_idx = bus_addr[5:2];
        if (int'(bus_addr[5:2]) < NCH) begin
          hit_sel = SEL_STRIDE;
        end
      end else begin
        case (bus_addr)
          OFS_STOP: hit_sel = SEL_STOP;
          OFS_STAT: hit_sel = SEL_STAT;
          OFS_IEN:  hit_sel = SEL_IEN;
          OFS_LOOP: hit_sel = SEL_LOOP;
          default:  hit_sel = SEL_NONE;
        endcase
      end
    end
  end

  assign clr_we = bus_wr && (hit_sel == SEL_STAT);
  assign ien_we = bus_wr && (hit_sel == SEL_IEN);

  dmac_chan_bank #(
    .NCH      (NCH),
    .LEN_W    (LEN_W),
    .STRIDE_W (STRIDE_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (bus_wr),
    .sel        (hit_sel),
    .idx        (hit_idx),
    .wdata      (bus_wdata),
    .cfg_addr   (cfg_addr),
    .cfg_xlen   (cfg_xlen),
    .cfg_ylen   (cfg_ylen),
    .cfg_ctrl   (cfg_ctrl),
    .cfg_stride (cfg_stride),
    .rd_data    (bank_rd)
  );

  dmac_launch #(
    .NCH (NCH)
  ) u_launch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (bus_wr),
    .sel      (hit_sel),
    .idx      (hit_idx),
    .wdata    (bus_wdata),
    .ch_start (ch_start),
    .ch_stop  (ch_stop),
    .ch_ring  (ch_ring),
    .loop_q   (loop_q)
  );

  dmac_evt_irq #(
    .NCH (NCH)
  ) u_evt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ch_evt (ch_evt),
    .clr_we (clr_we),
    .ien_we (ien_we),
    .wmask  (bus_wdata[NCH-1:0]),
    .stat_q (stat_q),
    .ien_q  (ien_q),
    .irq    (irq)
  );

  // Readback; the stop register is write-only and reads as zero
  always_comb begin
    case (hit_sel)
      SEL_CH_ADDR, SEL_CH_XLEN, SEL_CH_YLEN,
      SEL_CH_CTRL, SEL_STRIDE:  bus_rdata = bank_rd;
      SEL_STAT:                 bus_rdata = DATA_W'(stat_q);
      SEL_IEN:                  bus_rdata = DATA_W'(ien_q);
      SEL_LOOP:                 bus_rdata = loop_q;
      default:                  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dmac_regblk_chk.sv
module dmac_regblk_chk #(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [8:0]     bus_addr,
  input logic           bus_wr,
  input logic [31:0]    bus_wdata,
  input logic [NCH-1:0] ch_evt,
  input logic [NCH-1:0] ch_start,
  input logic [NCH-1:0] ch_stop,
  input logic [NCH-1:0] stat_q,
  input logic           irq
);

  // R4: a start pulse follows a write to that channel's base-address word
  p_start_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start != '0) |-> ($past(bus_wr) && ($past(bus_addr[8]) == 1'b0)
                          && ($past(bus_addr[3:0]) == 4'h0)
                          && (ch_start == (NCH'(1) << $past(bus_addr[7:4])))));

  // R5: a stop pulse repeats the mask written to the stop register
  p_stop_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_stop != '0) |-> ($past(bus_wr) && ($past(bus_addr) == 9'h140)
                         && (ch_stop == $past(bus_wdata[NCH-1:0]))));

  // R6: a status bit falls only under a clearing write with a one there
  p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(stat_q) & ~stat_q)
      & ~(($past(bus_wr) && ($past(bus_addr) == 9'h144))
          ? $past(bus_wdata[NCH-1:0]) : {NCH{1'b0}})) == '0));

  // R7: every event sets its status bit, whatever else happens that cycle
  p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_evt != '0) |=> ((stat_q & $past(ch_evt)) == $past(ch_evt)));

  // R8: the interrupt needs at least one pending status bit
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));

endmodule

bind dmac_regblk dmac_regblk_chk #(
  .NCH (NCH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .ch_evt    (ch_evt),
  .ch_start  (ch_start),
  .ch_stop   (ch_stop),
  .stat_q    (stat_q),
  .irq       (irq)
);

// File: tb/test_dmac_regblk.sv
module test_dmac_regblk;

  localparam int NCH = 16;
  localparam int LEN_W = 16;
  localparam int STRIDE_W = 16;

  logic                    clk;
  logic                    rst_n;
  logic [8:0]              bus_addr;
  logic                    bus_wr;
  logic [31:0]             bus_wdata;
  logic [31:0]             bus_rdata;
  logic [NCH-1:0]          ch_evt;
  logic [NCH-1:0]          ch_start;
  logic [NCH-1:0]          ch_stop;
  logic [NCH-1:0]          ch_ring;
  logic [NCH*32-1:0]       cfg_addr;
  logic [NCH*LEN_W-1:0]    cfg_xlen;
  logic [NCH*LEN_W-1:0]    cfg_ylen;
  logic [NCH*6-1:0]        cfg_ctrl;
  logic [NCH*STRIDE_W-1:0] cfg_stride;
  logic                    irq;

  int n_cmp = 0;
  int n_bad = 0;

  dmac_regblk #(.NCH(NCH), .LEN_W(LEN_W), .STRIDE_W(STRIDE_W)) i_dmac_regblk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_evt(ch_evt),
    .ch_start(ch_start), .ch_stop(ch_stop), .ch_ring(ch_ring),
    .cfg_addr(cfg_addr), .cfg_xlen(cfg_xlen), .cfg_ylen(cfg_ylen),
    .cfg_ctrl(cfg_ctrl), .cfg_stride(cfg_stride), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [8:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  // R2 and R3 readback, R8 enable and R9 loop register contents
  localparam vec_t VEC [NV] = '{
    '{1'b1, 9'h000, 32'h8000_1234, 32'h0,          4'd2},
    '{1'b0, 9'h000, 32'h0,         32'h8000_1234,  4'd2},
    '{1'b1, 9'h014, 32'hABCD_5678, 32'h0,          4'd2},
    '{1'b0, 9'h014, 32'h0,         32'h0000_5678,  4'd2},
    '{1'b1, 9'h0F8, 32'hFFFF_FFFF, 32'h0,          4'd2},
    '{1'b0, 9'h0F8, 32'h0,         32'h0000_FFFF,  4'd2},
    '{1'b1, 9'h07C, 32'hFFFF_FFF7, 32'h0,          4'd2},
    '{1'b0, 9'h07C, 32'h0,         32'h0000_0037,  4'd2},
    '{1'b1, 9'h13C, 32'h1234_0042, 32'h0,          4'd3},
    '{1'b0, 9'h13C, 32'h0,         32'h0000_0042,  4'd3},
    '{1'b1, 9'h148, 32'h0000_8001, 32'h0,          4'd8},
    '{1'b0, 9'h148, 32'h0,         32'h0000_8001,  4'd8},
    '{1'b1, 9'h150, 32'hFFFF_0005, 32'h0,          4'd9},
    '{1'b0, 9'h150, 32'h0,         32'hFFFF_0005,  4'd9},
    '{1'b0, 9'h010, 32'h0,         32'h0000_0000,  4'd2},
    '{1'b0, 9'h144, 32'h0,         32'h0000_0000,  4'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [NCH-1:0] m);
    @(negedge clk);
    ch_evt = m;
    @(negedge clk);
    ch_evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R1..: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; ch_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(9'h000, v);  check("R1 addr ch0", v, 32'h0);
    rd(9'h150, v);  check("R1 loop", v, 32'h0);
    rd(9'h144, v);  check("R1 status", v, 32'h0);
    check("R1 irq/start/stop/ring", {irq, 15'h0, ch_start | ch_stop | ch_ring}, 32'h0);
    check("R1 cfg_addr low", cfg_addr[31:0], 32'h0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        wr(VEC[i].a, VEC[i].d);
      end else begin
        rd(VEC[i].a, v);
        check($sformatf("R%0d vec %0d", VEC[i].rq, i), v, VEC[i].exp);
      end
    end

    // R2 / R3 configuration outputs
    check("R2 cfg_addr ch0", cfg_addr[0 +: 32], 32'h8000_1234);
    check("R2 cfg_xlen ch1", 32'(cfg_xlen[1*LEN_W +: LEN_W]), 32'h5678);
    check("R2 cfg_ctrl ch7", 32'(cfg_ctrl[7*6 +: 6]), 32'h37);
    check("R3 cfg_stride ch15", 32'(cfg_stride[15*STRIDE_W +: STRIDE_W]), 32'h42);

    // R4 start pulse: one cycle, only the written channel
    wr(9'h030, 32'h0000_1000);
    check("R4 start ch3", 32'(ch_start), 32'h0000_0008);
    @(negedge clk);
    check("R4 start gone", 32'(ch_start), 32'h0);
    wr(9'h034, 32'h0000_0010);
    check("R4 no start on length write", 32'(ch_start), 32'h0);

    // R5 stop pulse and write-only readback
    wr(9'h140, 32'h0000_0104);
    check("R5 stop mask", 32'(ch_stop), 32'h0000_0104);
    @(negedge clk);
    check("R5 stop gone", 32'(ch_stop), 32'h0);
    rd(9'h140, v);  check("R5 stop reads zero", v, 32'h0);

    // R6 / R8 events, masking and clearing (enable = 0x8001)
    pulse_evt(16'h0002);
    rd(9'h144, v);  check("R6 status set", v, 32'h0000_0002);
    check("R8 irq masked", 32'(irq), 32'h0);
    pulse_evt(16'h8000);
    check("R8 irq raised", 32'(irq), 32'h1);
    wr(9'h144, 32'h0000_0000);
    rd(9'h144, v);  check("R6 zero write keeps", v, 32'h0000_8002);
    wr(9'h144, 32'h0000_8000);
    rd(9'h144, v);  check("R6 clear bit 15", v, 32'h0000_0002);
    check("R8 irq dropped", 32'(irq), 32'h0);
    wr(9'h148, 32'h0000_0002);
    check("R8 irq on enable write", 32'(irq), 32'h1);

    // R7 event and clear in the same cycle
    @(negedge clk);
    ch_evt = 16'h0002; bus_addr = 9'h144; bus_wdata = 32'h0000_0002; bus_wr = 1'b1;
    @(negedge clk);
    ch_evt = '0; bus_wr = 1'b0;
    rd(9'h144, v);  check("R7 event wins", v, 32'h0000_0002);
    wr(9'h144, 32'h0000_0002);
    rd(9'h144, v);  check("R6 clear alone", v, 32'h0);

    // R9 ring enables need both bits
    check("R9 ring 0xFFFF0005", 32'(ch_ring), 32'h0000_0005);
    wr(9'h150, 32'h0004_0001);
    check("R9 ring half set", 32'(ch_ring), 32'h0);
    wr(9'h150, 32'h0003_0001);
    check("R9 ring ch0", 32'(ch_ring), 32'h0000_0001);

    // R10 unmapped and unaligned accesses
    wr(9'h14C, 32'hFFFF_FFFF);
    rd(9'h14C, v);  check("R10 0x14C reads zero", v, 32'h0);
    rd(9'h148, v);  check("R10 enable untouched", v, 32'h0000_0002);
    wr(9'h1FC, 32'hFFFF_FFFF);
    rd(9'h150, v);  check("R10 loop untouched", v, 32'h0003_0001);
    rd(9'h154, v);  check("R10 0x154 reads zero", v, 32'h0);
    wr(9'h001, 32'h0000_DEAD);
    check("R10 no start on unaligned", 32'(ch_start), 32'h0);
    rd(9'h000, v);  check("R10 addr ch0 untouched", v, 32'h8000_1234);
    rd(9'h001, v);  check("R10 unaligned reads zero", v, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule